// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Atomic Set and Clear

A pin controller reached through a simple register bus with address, write strobe, write data and combinational read data. It holds an output latch that drives the pins and a direction word that decides which pins are enabled as outputs. Software can change individual pins without a read-modify-write: a write-one-to-set register raises chosen latch bits, and a write-one-to-clear register lowers them. Pin inputs pass through a two-flop synchroniser and can then be read back.

The controller is built for one of four register widths. The number of pins always equals that width. Options fixed at build time choose:

- whether a direction bit of 1 means output or means input;
- whether pin numbering is mirrored within the word;
- whether register bytes sit in big-endian order on the bus;
- whether a set register exists without a clear register;
- whether the block may drive its pins at all.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While `rst` is high, the output latch clears to zero and the direction word resets to the value that drives no pin: 0 for output polarity, all ones for input polarity. As a result `pin_out` and `pin_oe` read zero on the cycle after a reset edge.
- R2: A write to address 0 (data) replaces the whole output latch. `pin_out` shows the new value on the cycle after the write edge.
- R3: A read of address 0 returns the pin input levels through a two-flop synchroniser. A level presented before clock edge k is readable after edge k+1.
- R4: In a build with a clear register, a write to address 1 (set) ORs the written word into the latch. Bits written as 0 keep their value.
- R5: In a build with a clear register, a write to address 2 (clear) forces each latch bit written as 1 to 0. Bits written as 0 keep their value.
- R6: In every build, a read of address 1 returns the output latch and not the pin levels. In a build without a clear register, a write to address 1 loads the whole latch, and address 2 behaves as unmapped.
- R7: With output polarity, a direction bit of 1 enables that pin's `pin_oe`. With input polarity, a direction bit of 1 makes the pin an input and clears its `pin_oe`. The new enables appear on the cycle after a write to address 3.
- R8: A read of address 3 returns the direction word last written.
- R9: With mirrored numbering, register bit b corresponds to pin WIDTH-1-b, for writes and for reads alike.
- R10: With big-endian lanes, register byte j appears in bus byte WIDTH/8-1-j. This option together with a 64-bit width is rejected at elaboration.
- R11: In the input-only build, writes to addresses 0, 1 and 2 leave the latch unchanged and `pin_oe` and `pin_out` stay zero. The direction word remains writable and readable.
- R12: Addresses 4 to 7 are unmapped. A write to one of them changes no pin output or enable, and a read of one returns zero.
- R13: WIDTH must be 8, 16, 32 or 64, and any other value is rejected at elaboration. Every width provides WIDTH independent pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | WIDTH | Write data in bus lane order |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| pin_in | input | WIDTH | Asynchronous pin levels, pin n on bit n |
| pin_out | output | WIDTH | Output latch, pin n on bit n |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
Four builds run side by side on one bus:
- 16 bits with plain mapping;
- 32 bits with mirrored numbering, big-endian lanes and input polarity;
- 16 bits set-only with big-endian lanes;
- 64 bits input-only with mirrored numbering.

Patterns with both halves of each byte different (`A5C3...`, `0102_0408...`) separate a byte swap from a bit mirror and from both applied together, which a symmetric word such as all ones would hide. Overlapping set and clear masks over a half-filled latch tell OR and AND-NOT from a plain load. Holding a read of address 0 while the pin inputs step shows the two-cycle synchroniser delay.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_DATA = 3'd0,
      RA_SET  = 3'd1,
      RA_CLR  = 3'd2,
      RA_DIR  = 3'd3
   } gpio_reg_e;

   // Bus bit that carries logical pin n after optional mirroring and lane swap.
   function automatic int lane_src(input int n, input int width,
                                   input bit mirror, input bit swap);
      int k;
      k = mirror ? (width - 1 - n) : n;
      if (swap)
         return 8 * ((width / 8) - 1 - (k / 8)) + (k % 8);
      return k;
   endfunction

endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
   parameter int WIDTH     = 16,
   parameter bit BIT_REV   = 1'b0,
   parameter bit BYTE_SWAP = 1'b0
) (
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] dst
);
   // Mirror and lane swap commute and are each self-inverse, so the
   // same wiring serves bus-to-pin and pin-to-bus directions.
   for (genvar n = 0; n < WIDTH; n++) begin : g_bit
      localparam int SRC = gpio_mmio_pkg::lane_src(n, WIDTH, BIT_REV, BYTE_SWAP);
      assign dst[n] = src[SRC];
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
   parameter int WIDTH        = 16,
   parameter bit HAS_CLEAR    = 1'b1,
   parameter bit DIR_IS_INPUT = 1'b0,
   parameter bit INPUT_ONLY   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] wr_val,
   input  logic             we_data,
   input  logic             we_set,
   input  logic             we_clr,
   input  logic             we_dir,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] oe
);
   localparam logic [WIDTH-1:0] DIR_RST = {WIDTH{DIR_IS_INPUT}};

   logic [WIDTH-1:0] latch_d;

   always_comb begin
      latch_d = latch_q;
      if (!INPUT_ONLY) begin
         if (we_data)
            latch_d = wr_val;
         else if (we_set)
            latch_d = HAS_CLEAR ? (latch_q | wr_val) : wr_val;
         else if (we_clr && HAS_CLEAR)
            latch_d = latch_q & ~wr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         latch_q <= '0;
         dir_q   <= DIR_RST;
      end else begin
         latch_q <= latch_d;
         if (we_dir) dir_q <= wr_val;
      end
   end

   if (INPUT_ONLY) begin : g_no_drive
      assign oe = '0;
   end else if (DIR_IS_INPUT) begin : g_dir_in
      assign oe = ~dir_q;
   end else begin : g_dir_out
      assign oe = dir_q;
   end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
   parameter int WIDTH        = 16,
   parameter bit DIR_IS_INPUT = 1'b0,
   parameter bit BIT_REV      = 1'b0,
   parameter bit BYTE_SWAP    = 1'b0,
   parameter bit HAS_CLEAR    = 1'b1,
   parameter bit INPUT_ONLY   = 1'b0,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           bus_wr,
   input  logic [gpio_mmio_pkg::ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]               bus_wdata,
   output logic [WIDTH-1:0]               bus_rdata,
   input  logic [WIDTH-1:0]               pin_in,
   output logic [WIDTH-1:0]               pin_out,
   output logic [WIDTH-1:0]               pin_oe
);
   import gpio_mmio_pkg::*;

   if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
   end
   if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
      $error("gpio_mmio_ctrl: big-endian lanes unsupported at 64 bits");
   end

   logic [WIDTH-1:0] wr_logical;
   logic [WIDTH-1:0] rd_logical;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic             we_data, we_set, we_clr, we_dir;

   gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
      .src(bus_wdata), .dst(wr_logical));

   gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
      .src(rd_logical), .dst(bus_rdata));

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync));

   assign we_data = bus_wr && (bus_addr == RA_DATA);
   assign we_set  = bus_wr && (bus_addr == RA_SET);
   assign we_clr  = bus_wr && (bus_addr == RA_CLR);
   assign we_dir  = bus_wr && (bus_addr == RA_DIR);

   gpio_out_regs #(
      .WIDTH(WIDTH), .HAS_CLEAR(HAS_CLEAR),
      .DIR_IS_INPUT(DIR_IS_INPUT), .INPUT_ONLY(INPUT_ONLY)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_val(wr_logical),
      .we_data(we_data), .we_set(we_set), .we_clr(we_clr), .we_dir(we_dir),
      .latch_q(latch_q), .dir_q(dir_q), .oe(pin_oe));

   always_comb begin
      case (bus_addr)
         RA_DATA: rd_logical = pins_sync;
         RA_SET:  rd_logical = latch_q;
         RA_DIR:  rd_logical = dir_q;
         default: rd_logical = '0;
      endcase
   end

   assign pin_out = latch_q;
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk #(
   parameter int WIDTH        = 16,
   parameter bit DIR_IS_INPUT = 1'b0,
   parameter bit BIT_REV      = 1'b0,
   parameter bit BYTE_SWAP    = 1'b0,
   parameter bit HAS_CLEAR    = 1'b1,
   parameter bit INPUT_ONLY   = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe
);
   logic [WIDTH-1:0] wv;       // written word in pin order
   logic [WIDTH-1:0] lat_bus;  // pin_out in bus order

   for (genvar n = 0; n < WIDTH; n++) begin : g_map
      localparam int S = gpio_mmio_pkg::lane_src(n, WIDTH, BIT_REV, BYTE_SWAP);
      assign wv[n]      = bus_wdata[S];
      assign lat_bus[S] = pin_out[n];
   end

   // R1: reset leaves nothing driven
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (pin_out == '0 && pin_oe == '0));

   // R2: data write loads the latch
   a_r2_data_load: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 3'd0 && !INPUT_ONLY) |=> pin_out == $past(wv));

   // R4: set register ORs
   a_r4_set_or: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 3'd1 && HAS_CLEAR && !INPUT_ONLY)
      |=> pin_out == $past(pin_out | wv));

   // R5: clear register AND-NOTs
   a_r5_clr_andnot: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 3'd2 && HAS_CLEAR && !INPUT_ONLY)
      |=> pin_out == $past(pin_out & ~wv));

   // R6: set-only build loads the whole latch
   a_r6_set_load: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 3'd1 && !HAS_CLEAR && !INPUT_ONLY)
      |=> pin_out == $past(wv));

   // R6: set register reads back the latch
   a_r6_set_read: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == 3'd1) |-> bus_rdata == lat_bus);

   // R7: direction write sets enables with the built polarity
   a_r7_dir_polarity: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 3'd3 && !INPUT_ONLY)
      |=> pin_oe == (DIR_IS_INPUT ? ~$past(wv) : $past(wv)));

   // R11: input-only build never drives
   a_r11_no_drive: assert property (@(posedge clk) disable iff (rst)
      INPUT_ONLY |-> (pin_oe == '0 && pin_out == '0));

   // R12: unmapped reads return zero
   a_r12_unmapped_read: assert property (@(posedge clk) disable iff (rst)
      (bus_addr[2]) |-> bus_rdata == '0);

   // R12: unmapped writes change nothing at the pins
   a_r12_unmapped_write: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr[2]) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
   .WIDTH(WIDTH), .DIR_IS_INPUT(DIR_IS_INPUT), .BIT_REV(BIT_REV),
   .BYTE_SWAP(BYTE_SWAP), .HAS_CLEAR(HAS_CLEAR), .INPUT_ONLY(INPUT_ONLY)
) u_chk (
   .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/sim_gpio_mmio_ctrl.sv
module sim_gpio_mmio_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 4;

   // per-build configuration, index = instance number
   int W      [NI] = '{16, 32, 16, 64};
   bit MIR    [NI] = '{0, 1, 0, 1};
   bit SWP    [NI] = '{0, 1, 1, 0};
   bit DINV   [NI] = '{0, 1, 0, 0};
   bit HASCLR [NI] = '{1, 1, 0, 1};
   bit INONLY [NI] = '{0, 0, 0, 1};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [63:0] wdata = '0;
   logic [63:0] pin_in = '0;

   logic [15:0] rd0, po0, oe0;
   logic [31:0] rd1, po1, oe1;
   logic [15:0] rd2, po2, oe2;
   logic [63:0] rd3, po3, oe3;

   int    checks = 0;
   int    errors = 0;
   bit    started = 0;
   bit    done = 0;
   string cur_req = "R1";

   // behavioural model state, pin order
   logic [63:0] m_lat [NI];
   logic [63:0] m_dir [NI];
   logic [63:0] m_s1  [NI];
   logic [63:0] m_s2  [NI];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mmio_ctrl #(.WIDTH(16)) u0 (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(wdata[15:0]), .bus_rdata(rd0), .pin_in(pin_in[15:0]),
      .pin_out(po0), .pin_oe(oe0));
   gpio_mmio_ctrl #(.WIDTH(32), .BIT_REV(1'b1), .BYTE_SWAP(1'b1), .DIR_IS_INPUT(1'b1)) u1 (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(wdata[31:0]), .bus_rdata(rd1), .pin_in(pin_in[31:0]),
      .pin_out(po1), .pin_oe(oe1));
   gpio_mmio_ctrl #(.WIDTH(16), .HAS_CLEAR(1'b0), .BYTE_SWAP(1'b1)) u2 (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(wdata[15:0]), .bus_rdata(rd2), .pin_in(pin_in[15:0]),
      .pin_out(po2), .pin_oe(oe2));
   gpio_mmio_ctrl #(.WIDTH(64), .INPUT_ONLY(1'b1), .BIT_REV(1'b1)) u3 (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(wdata), .bus_rdata(rd3), .pin_in(pin_in),
      .pin_out(po3), .pin_oe(oe3));

   function automatic logic [63:0] mask_of(int i);
      return (W[i] == 64) ? '1 : ((64'd1 << W[i]) - 64'd1);
   endfunction

   function automatic int bus_bit(int i, int n);
      int k = MIR[i] ? W[i] - 1 - n : n;
      return SWP[i] ? (W[i]/8 - 1 - k/8) * 8 + k % 8 : k;
   endfunction

   function automatic logic [63:0] to_pins(int i, logic [63:0] w);
      logic [63:0] r = '0;
      for (int n = 0; n < W[i]; n++) r[n] = w[bus_bit(i, n)];
      return r;
   endfunction

   function automatic logic [63:0] to_bus(int i, logic [63:0] p);
      logic [63:0] r = '0;
      for (int n = 0; n < W[i]; n++) r[bus_bit(i, n)] = p[n];
      return r;
   endfunction

   // model advances on each rising edge
   always @(posedge clk) begin
      for (int i = 0; i < NI; i++) begin
         if (rst) begin
            m_lat[i] = '0;
            m_dir[i] = DINV[i] ? mask_of(i) : '0;
            m_s1[i] = '0;
            m_s2[i] = '0;
         end else begin
            logic [63:0] v;
            v = to_pins(i, wdata & mask_of(i));
            m_s2[i] = m_s1[i];
            m_s1[i] = pin_in & mask_of(i);
            if (bus_wr) begin
               case (bus_addr)
                  3'd0: if (!INONLY[i]) m_lat[i] = v;
                  3'd1: if (!INONLY[i]) m_lat[i] = HASCLR[i] ? (m_lat[i] | v) : v;
                  3'd2: if (!INONLY[i] && HASCLR[i]) m_lat[i] = m_lat[i] & ~v;
                  3'd3: m_dir[i] = v;
                  default: ;
               endcase
            end
         end
      end
      started = 1;
   end

   task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (started && !done) begin
         for (int i = 0; i < NI; i++) begin
            logic [63:0] a_rd, a_po, a_oe, e_oe, sel;
            case (i)
               0: begin a_rd = 64'(rd0); a_po = 64'(po0); a_oe = 64'(oe0); end
               1: begin a_rd = 64'(rd1); a_po = 64'(po1); a_oe = 64'(oe1); end
               2: begin a_rd = 64'(rd2); a_po = 64'(po2); a_oe = 64'(oe2); end
               default: begin a_rd = rd3; a_po = po3; a_oe = oe3; end
            endcase
            e_oe = INONLY[i] ? '0 : (DINV[i] ? (~m_dir[i] & mask_of(i)) : m_dir[i]);
            case (bus_addr)
               3'd0: sel = m_s2[i];
               3'd1: sel = m_lat[i];
               3'd3: sel = m_dir[i];
               default: sel = '0;
            endcase
            cmp($sformatf("u%0d pin_out", i), a_po, m_lat[i]);
            cmp($sformatf("u%0d pin_oe", i), a_oe, e_oe);
            cmp($sformatf("u%0d rdata@%0d", i, bus_addr), a_rd, to_bus(i, sel));
         end
      end
   end

   task automatic acc(bit w, logic [2:0] a, logic [63:0] d, string tag);
      @(posedge clk);
      #2;
      cur_req = tag;
      bus_wr = w;
      bus_addr = a;
      wdata = d;
   endtask

   task automatic drive_pins(logic [63:0] v, int cycles, string tag);
      acc(1'b0, 3'd0, '0, tag);
      pin_in = v;
      repeat (cycles) @(posedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      acc(0, 3'd3, '0, "R1");                       // R1 direction reset value
      acc(0, 3'd1, '0, "R1");
      acc(1, 3'd5, '1, "R12");                      // R12 unmapped writes
      acc(1, 3'd7, '1, "R12");
      acc(0, 3'd4, '0, "R12");
      acc(0, 3'd6, '0, "R12");
      acc(1, 3'd0, 64'hA5C3_0F96_3C5A_E718, "R2");  // R2 whole-latch load
      acc(1, 3'd0, '1, "R2");
      acc(0, 3'd1, '0, "R2");
      acc(1, 3'd0, '0, "R2");
      acc(0, 3'd1, '0, "R2");
      acc(1, 3'd0, 64'h00F0_00F0_00F0_00F0, "R4");  // R4 set ORs in
      acc(1, 3'd1, 64'h0F0F_0F0F_0F0F_0F0F, "R4");
      acc(0, 3'd1, '0, "R4");
      acc(1, 3'd1, 64'h8001_8001_8001_8001, "R4");
      acc(1, 3'd2, 64'h00FF_00FF_00FF_00FF, "R5");  // R5 clear AND-NOT
      acc(0, 3'd1, '0, "R5");
      acc(1, 3'd2, '1, "R5");
      acc(0, 3'd1, '0, "R5");
      acc(1, 3'd1, 64'h1234_5678_9ABC_DEF0, "R6");  // R6 set readback / set-only load
      acc(0, 3'd1, '0, "R6");
      acc(1, 3'd1, 64'h0000_FFFF_0000_FFFF, "R6");
      acc(0, 3'd1, '0, "R6");
      acc(1, 3'd2, 64'h0000_00FF_0000_00FF, "R6");
      acc(0, 3'd2, '0, "R6");
      acc(1, 3'd3, 64'h00FF_0F0F_3333_5555, "R7");  // R7 polarity
      acc(0, 3'd3, '0, "R8");                       // R8 readback
      acc(1, 3'd3, '0, "R7");
      acc(0, 3'd3, '0, "R8");
      acc(1, 3'd3, '1, "R7");
      acc(0, 3'd3, '0, "R8");
      drive_pins(64'hDEAD_BEEF_0123_4567, 4, "R3"); // R3 synchroniser
      drive_pins(64'h5A5A_F00F_C3C3_9696, 1, "R3");
      drive_pins(64'h0000_0000_0000_0001, 4, "R9"); // R9 mirrored numbering
      acc(1, 3'd0, 64'h0000_0000_0000_0001, "R9");
      acc(1, 3'd3, 64'h0000_0000_0000_0003, "R9");
      acc(0, 3'd3, '0, "R9");
      acc(1, 3'd0, 64'h0102_0408_1020_4080, "R10"); // R10 lane order
      acc(0, 3'd1, '0, "R10");
      drive_pins(64'h0000_0000_0000_00FF, 3, "R10");
      acc(1, 3'd0, '1, "R11");                      // R11 input-only
      acc(1, 3'd1, '1, "R11");
      acc(1, 3'd3, 64'h00FF_00FF_00FF_00FF, "R11");
      acc(0, 3'd1, '0, "R11");
      acc(1, 3'd0, '1, "R13");                      // R13 all widths
      acc(1, 3'd3, '1, "R13");
      acc(0, 3'd1, '0, "R13");
      acc(0, 3'd0, '0, "R13");
      repeat (3) @(posedge clk);
      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end
endmodule